// File: doc/BRIEF.md
# Sequence-Tagged Sampling Channel

A single-slot channel that carries values from one producer to one consumer. Neither side ever waits for the other. Each side acts on its own trigger pulse. The producer overwrites the slot whenever it fires. Every value it stores receives a tag one higher than the previous tag.

The consumer may sample the slot at any time. It keeps the tag of the value it last took. A freshness flag reports whether the slot holds a value the consumer has not yet taken. Because neither side can be refused, there is no back-pressure in either direction. The producer's trigger is always accepted. The consumer's trigger always returns the current slot contents, even when those contents are stale.

When both triggers fire in the same cycle, the write lands first. The consumer then receives the new payload and its new tag together, in the same update.

Top module: `seqchan_top`

## Requirements
- R1: After reset, `dst_payload` is 0, `dst_tag` is 0 and `dst_fresh` is 0.
- R2: A cycle with `src_put` high stores `src_payload` and raises the stored tag by one, modulo 2^TAG_W. If `dst_fresh` was 0 and no read happens in the same cycle, `dst_fresh` is 1 in the next cycle.
- R3: `dst_fresh` is 1 exactly when the stored tag differs from the consumer's last-seen tag. In a cycle with neither trigger, it does not change.
- R4: A cycle with `dst_take` high loads the slot payload into `dst_payload` and the slot tag into `dst_tag`, visible from the next cycle. The last-seen tag then equals the stored tag, so `dst_fresh` is 0.
- R5: Several writes with no read in between leave only the newest payload. A later read returns that payload with a tag equal to the number of writes made, modulo 2^TAG_W.
- R6: When `src_put` and `dst_take` are both high in one cycle, the read returns that cycle's `src_payload` and its new tag, and `dst_fresh` is 0 afterwards.
- R7: With `dst_take` low, `dst_payload` and `dst_tag` hold their values. A read while `dst_fresh` is 0 returns the same payload and tag again.
- R8: Tags wrap modulo 256 with the default TAG_W=8. After 255 unread writes `dst_fresh` is 1. After exactly 256 unread writes the tags alias, and `dst_fresh` reads 0.
- R9: Neither side ever stalls. A write on every consecutive cycle advances the tag once per cycle, and a read is accepted on any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both triggers |
| rst_n | input | 1 | Active-low synchronous reset |
| src_put | input | 1 | Producer trigger: write `src_payload` this cycle |
| src_payload | input | DATA_W | Value to store |
| dst_take | input | 1 | Consumer trigger: sample the slot this cycle |
| dst_payload | output | DATA_W | Payload from the most recent read |
| dst_tag | output | TAG_W | Tag from the most recent read (the last-seen tag) |
| dst_fresh | output | 1 | Slot holds a value not yet taken |

## Verification
The channel is tested with the following patterns. Each one separates a different fault:

- **Single write then read.** Shows whether tagging and the freshness flag move at the right edges.
- **Repeated reads of a stale slot.** Separates a consumer that re-samples correctly from one that clears or corrupts its output.
- **Burst of back-to-back writes before one read.** Shows whether overwriting keeps the newest value and whether tags count every write.
- **Write and read in the same cycle.** Distinguishes write-first ordering from read-first ordering.
- **Runs of 255 and 256 unread writes.** Expose the modulo wrap of the tag and the aliasing case that equality-based freshness cannot see.

// File: rtl/seqchan_pkg.sv
package seqchan_pkg;
  localparam int DEF_DATA_W = 16;
  localparam int DEF_TAG_W  = 8;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_BOTH  = 2'b11
  } chan_op_e;

  function automatic chan_op_e decode_op(input logic put, input logic take);
    return chan_op_e'({take, put});
  endfunction
endpackage

// File: rtl/seqchan_slot.sv
module seqchan_slot #(
  parameter int DATA_W = seqchan_pkg::DEF_DATA_W,
  parameter int TAG_W  = seqchan_pkg::DEF_TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              put,
  input  logic [DATA_W-1:0] payload_in,
  output logic [DATA_W-1:0] slot_payload,
  output logic [TAG_W-1:0]  slot_tag,
  output logic [DATA_W-1:0] view_payload,
  output logic [TAG_W-1:0]  view_tag
);
  localparam logic [TAG_W-1:0] TAG_ONE = TAG_W'(1);

  logic [TAG_W-1:0] tag_next;

  assign tag_next = slot_tag + TAG_ONE;

  // Write-first view for a read issued in the same cycle
  assign view_payload = put ? payload_in : slot_payload;
  assign view_tag     = put ? tag_next   : slot_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_payload <= '0;
      slot_tag     <= '0;
    end else if (put) begin
      slot_payload <= payload_in;
      slot_tag     <= tag_next;
    end
  end
endmodule

// File: rtl/seqchan_sampler.sv
module seqchan_sampler #(
  parameter int DATA_W = seqchan_pkg::DEF_DATA_W,
  parameter int TAG_W  = seqchan_pkg::DEF_TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] view_payload,
  input  logic [TAG_W-1:0]  view_tag,
  output logic [DATA_W-1:0] held_payload,
  output logic [TAG_W-1:0]  seen_tag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_payload <= '0;
      seen_tag     <= '0;
    end else if (take) begin
      held_payload <= view_payload;
      seen_tag     <= view_tag;
    end
  end
endmodule

// File: rtl/seqchan_fresh.sv
module seqchan_fresh #(
  parameter int TAG_W = seqchan_pkg::DEF_TAG_W
) (
  input  logic [TAG_W-1:0] stored_tag,
  input  logic [TAG_W-1:0] seen_tag,
  output logic             fresh
);
  assign fresh = (stored_tag != seen_tag);
endmodule

// File: rtl/seqchan_top.sv
module seqchan_top #(
  parameter int DATA_W = seqchan_pkg::DEF_DATA_W,
  parameter int TAG_W  = seqchan_pkg::DEF_TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_put,
  input  logic [DATA_W-1:0] src_payload,
  input  logic              dst_take,
  output logic [DATA_W-1:0] dst_payload,
  output logic [TAG_W-1:0]  dst_tag,
  output logic              dst_fresh
);
  import seqchan_pkg::*;

  logic [DATA_W-1:0] slot_payload;
  logic [TAG_W-1:0]  slot_tag;
  logic [DATA_W-1:0] view_payload;
  logic [TAG_W-1:0]  view_tag;
  chan_op_e          op;
  logic              do_put;
  logic              do_take;

  assign op      = decode_op(src_put, dst_take);
  assign do_put  = (op == OP_WRITE) || (op == OP_BOTH);
  assign do_take = (op == OP_READ)  || (op == OP_BOTH);

  seqchan_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_slot (
    .clk          (clk),
    .rst_n        (rst_n),
    .put          (do_put),
    .payload_in   (src_payload),
    .slot_payload (slot_payload),
    .slot_tag     (slot_tag),
    .view_payload (view_payload),
    .view_tag     (view_tag)
  );

  seqchan_sampler #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_sampler (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (do_take),
    .view_payload (view_payload),
    .view_tag     (view_tag),
    .held_payload (dst_payload),
    .seen_tag     (dst_tag)
  );

  seqchan_fresh #(.TAG_W(TAG_W)) u_fresh (
    .stored_tag (slot_tag),
    .seen_tag   (dst_tag),
    .fresh      (dst_fresh)
  );
endmodule

// File: rtl/seqchan_checker.sv
module seqchan_checker #(
  parameter int DATA_W = seqchan_pkg::DEF_DATA_W,
  parameter int TAG_W  = seqchan_pkg::DEF_TAG_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_put,
  input logic [DATA_W-1:0] src_payload,
  input logic              dst_take,
  input logic [DATA_W-1:0] dst_payload,
  input logic [TAG_W-1:0]  dst_tag,
  input logic              dst_fresh,
  input logic [TAG_W-1:0]  slot_tag
);
  AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    src_put |=> slot_tag == TAG_W'($past(slot_tag) + 1'b1)); // R2
  AST_WRITE_MAKES_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (src_put && !dst_take && !dst_fresh) |=> dst_fresh); // R2
  AST_FRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_put && !dst_take) |=> $stable(dst_fresh)); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dst_take |=> !dst_fresh); // R4
  AST_SAME_CYCLE_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_take && src_put) |=> dst_payload == $past(src_payload)); // R6
  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_take |=> ($stable(dst_payload) && $stable(dst_tag))); // R7
  AST_STALE_REREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_take && !src_put && !dst_fresh) |=> $stable(dst_tag)); // R7
endmodule

bind seqchan_top seqchan_checker #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_put     (src_put),
  .src_payload (src_payload),
  .dst_take    (dst_take),
  .dst_payload (dst_payload),
  .dst_tag     (dst_tag),
  .dst_fresh   (dst_fresh),
  .slot_tag    (slot_tag)
);

// File: tb/tb_seqchan_top.sv
module tb_seqchan_top;
  localparam int DW = 16;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          src_put = 1'b0;
  logic [DW-1:0] src_payload = '0;
  logic          dst_take = 1'b0;
  logic [DW-1:0] dst_payload;
  logic [TW-1:0] dst_tag;
  logic          dst_fresh;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  seqchan_top #(.DATA_W(DW), .TAG_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .src_put(src_put), .src_payload(src_payload),
    .dst_take(dst_take), .dst_payload(dst_payload), .dst_tag(dst_tag),
    .dst_fresh(dst_fresh)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, apply at posedge, return at next negedge
  task automatic cyc(input logic put, input logic [DW-1:0] pay, input logic take);
    src_put = put; src_payload = pay; dst_take = take;
    @(posedge clk);
    @(negedge clk);
    src_put = 1'b0; dst_take = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "payload", 32'(dst_payload), 32'h0);
    check("R1", "tag", 32'(dst_tag), 32'h0);
    check("R1", "fresh", 32'(dst_fresh), 32'h0);
  endtask

  task automatic t_single();
    cyc(1'b1, 16'h00A5, 1'b0);
    check("R2", "fresh after write", 32'(dst_fresh), 32'h1);
    check("R7", "payload held w/o read", 32'(dst_payload), 32'h0);
    cyc(1'b0, '0, 1'b1);
    check("R4", "read payload", 32'(dst_payload), 32'h00A5);
    check("R4", "read tag", 32'(dst_tag), 32'h1);
    check("R3", "fresh after read", 32'(dst_fresh), 32'h0);
  endtask

  task automatic t_stale();
    cyc(1'b0, '0, 1'b1);
    check("R7", "stale reread payload", 32'(dst_payload), 32'h00A5);
    check("R7", "stale reread tag", 32'(dst_tag), 32'h1);
    check("R9", "read accepted, fresh low", 32'(dst_fresh), 32'h0);
  endtask

  task automatic t_overwrite();
    cyc(1'b1, 16'h1111, 1'b0);
    cyc(1'b1, 16'h2222, 1'b0);
    cyc(1'b1, 16'h3333, 1'b0);
    cyc(1'b0, '0, 1'b1);
    check("R5", "newest payload", 32'(dst_payload), 32'h3333);
    check("R9", "tag counts burst", 32'(dst_tag), 32'h4);
  endtask

  task automatic t_same_cycle();
    cyc(1'b1, 16'h4444, 1'b1);
    check("R6", "write-first payload", 32'(dst_payload), 32'h4444);
    check("R6", "write-first tag", 32'(dst_tag), 32'h5);
    check("R6", "fresh low after", 32'(dst_fresh), 32'h0);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 255; i++) cyc(1'b1, 16'(i + 16'h100), 1'b0);
    check("R8", "fresh after 255", 32'(dst_fresh), 32'h1);
    cyc(1'b0, '0, 1'b1);
    check("R8", "tag wrapped", 32'(dst_tag), 32'h4);
    check("R8", "payload after 255", 32'(dst_payload), 32'h01FE);
    for (int i = 0; i < 256; i++) cyc(1'b1, 16'(i + 16'h200), 1'b0);
    check("R8", "aliased after 256", 32'(dst_fresh), 32'h0);
    cyc(1'b1, 16'hBEEF, 1'b0);
    check("R8", "fresh after 257", 32'(dst_fresh), 32'h1);
    cyc(1'b0, '0, 1'b1);
    check("R8", "tag after 257", 32'(dst_tag), 32'h5);
    check("R8", "payload after 257", 32'(dst_payload), 32'hBEEF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_stale();
    t_overwrite();
    t_same_cycle();
    t_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule